// File: doc/BRIEF.md
# Relocatable Register Window Translator

This block lets a host reach a large internal register space through a few small, fixed windows in its own address map. Each window owns an entry in an admin table. The entry holds a relocatable base, stored in dword units, and a pretend word. The pretend word can relabel forwarded accesses with a different function ID or port. A host access that lands inside window N is sent to the internal bus at that window's base plus the byte offset inside the window.

Software moves a window by writing its base through the configuration port. After that write, host accesses to the window reach the new region. An entry whose base is all ones is invalid, and accesses through it are stopped at the block. When a function-ID pretend is written, the table normalises it. Any earlier port override is cleared, and a function ID without its VF-valid bit is reduced to its PF ID. The translation path is combinational. Only the admin table is clocked.

Top module: `bar_window_xlat`

## Requirements
- R1: After reset, every entry's base word reads back as 0x003FFFFF, which is all ones in 22 bits and means invalid. Every pretend word reads back as 0.
- R2: The configuration port decodes each entry as 8 bytes at ADMIN_BASE + 8*N. Byte +0 is the base word, which keeps data bits 21:0. Byte +4 is the pretend word: control in bits 15:0 and function ID in bits 31:16. A write outside the admin range changes nothing, and a read there returns 0.
- R3: A host address in WIN_BASE + N*WIN_BYTES + o is forwarded to internal byte address (base*4 + o) mod 2^24.
- R4: A forwarded access copies the host write flag and write data. On a read, the host sees the internal read data.
- R5: A host access through an invalid entry is not forwarded and raises h_err in the same cycle. A read through such an entry returns 0xFFFFFFFF.
- R6: A host address outside the window area is not forwarded, raises no error, and reads 0.
- R7: The control word has these fields: bits 1:0 port, bit 2 use-port, bit 3 port-override, bit 4 function-override, bit 5 concrete. When a pretend write sets bit 4, the stored port and use-port become 0 and the port-override bit becomes 1.
- R8: A function ID holds the PF ID in bits 3:0, the VF ID in bits 11:4 and VF-valid in bit 15. When a pretend write sets bit 4 with VF-valid clear, only the PF ID is stored.
- R9: The forwarded function ID is the entry's stored ID when bit 4 is set. Otherwise it is DFLT_FID (0x0007).
- R10: The forwarded port is the entry's port when both bits 2 and 3 are set. Otherwise it is DFLT_PORT (1).
- R11: A table write takes effect from the next cycle. A host access in the same cycle as the write uses the old entry.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Admin table write strobe |
| cfg_addr | input | 12 | Admin byte address |
| cfg_wdata | input | 32 | Admin write data |
| cfg_rdata | output | 32 | Admin read data (combinational) |
| h_valid | input | 1 | Host access request |
| h_we | input | 1 | Host write flag |
| h_addr | input | 16 | Host byte address |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data |
| h_err | output | 1 | Access through an invalid window |
| i_valid | output | 1 | Internal access request |
| i_we | output | 1 | Internal write flag |
| i_addr | output | 24 | Internal byte address |
| i_wdata | output | 32 | Internal write data |
| i_rdata | input | 32 | Internal read data |
| i_fid | output | 16 | Effective function ID |
| i_port | output | 2 | Effective port |

## Verification
Relocating a window and accessing that same window can happen in the same cycle. The bench provokes this by holding a host read on window 1 while it writes a new base for window 1. The forwarded address must still use the old base in that cycle and switch to the new base one cycle later. The bench judges this against its own record of the table. It also sweeps every window with several in-window offsets, including a base that wraps the 24-bit space.

// File: rtl/bar_window_xlat.sv
module bar_window_xlat #(
  parameter int NWIN      = 4,
  parameter int WIN_BYTES = 4096,
  parameter int IADDR_W   = 24,
  parameter int DATA_W    = 32,
  parameter int HADDR_W   = 16,
  parameter logic [HADDR_W-1:0] WIN_BASE = 16'h4000,
  parameter int CFG_AW    = 12,
  parameter logic [CFG_AW-1:0] ADMIN_BASE = 12'h100,
  parameter int PORT_W    = 2,
  parameter int PF_W      = 4,
  parameter logic [15:0] DFLT_FID = 16'h0007,
  parameter logic [PORT_W-1:0] DFLT_PORT = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [CFG_AW-1:0]  cfg_addr,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  input  logic               h_valid,
  input  logic               h_we,
  input  logic [HADDR_W-1:0] h_addr,
  input  logic [DATA_W-1:0]  h_wdata,
  output logic [DATA_W-1:0]  h_rdata,
  output logic               h_err,
  output logic               i_valid,
  output logic               i_we,
  output logic [IADDR_W-1:0] i_addr,
  output logic [DATA_W-1:0]  i_wdata,
  input  logic [DATA_W-1:0]  i_rdata,
  output logic [15:0]        i_fid,
  output logic [PORT_W-1:0]  i_port
);
  localparam int IDX_W  = $clog2(NWIN);
  localparam int WOFF_W = $clog2(WIN_BYTES);
  localparam int OFF_W  = IADDR_W - 2;
  localparam int B_USE  = PORT_W;
  localparam int B_PP   = PORT_W + 1;
  localparam int B_FUNC = PORT_W + 2;
  localparam int B_VFV  = 15;
  localparam logic [HADDR_W-1:0] AREA = HADDR_W'(NWIN * WIN_BYTES);
  localparam logic [CFG_AW-1:0]  SPAN = CFG_AW'(NWIN * 8);

  logic [OFF_W-1:0] offs [NWIN];
  logic [15:0]      ctl  [NWIN];
  logic [15:0]      fid  [NWIN];

  logic [CFG_AW-1:0] crel;
  logic              cfg_hit;
  logic [IDX_W-1:0]  cidx;
  logic [15:0]       nctl, nfid;

  assign crel    = cfg_addr - ADMIN_BASE;
  assign cfg_hit = (cfg_addr >= ADMIN_BASE) && (crel < SPAN) && (crel[1:0] == 2'b00);
  assign cidx    = crel[3 +: IDX_W];

  always_comb begin
    nctl = cfg_wdata[15:0];
    nfid = cfg_wdata[31:16];
    if (nctl[B_FUNC]) begin
      nctl[PORT_W-1:0] = '0;
      nctl[B_USE]      = 1'b0;
      nctl[B_PP]       = 1'b1;
      if (!nfid[B_VFV]) nfid = 16'(nfid[PF_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < NWIN; n++) begin
        offs[n] <= '1;
        ctl[n]  <= '0;
        fid[n]  <= '0;
      end
    end else if (cfg_wr && cfg_hit) begin
      if (!crel[2]) offs[cidx] <= cfg_wdata[OFF_W-1:0];
      else begin
        ctl[cidx] <= nctl;
        fid[cidx] <= nfid;
      end
    end
  end

  assign cfg_rdata = !cfg_hit ? '0 :
                     crel[2]  ? {fid[cidx], ctl[cidx]} : 32'(offs[cidx]);

  logic [HADDR_W-1:0] hrel;
  logic               in_area, ent_ok;
  logic [IDX_W-1:0]   widx;
  logic [WOFF_W-1:0]  woff;

  assign hrel    = h_addr - WIN_BASE;
  assign in_area = (h_addr >= WIN_BASE) && (hrel < AREA);
  assign widx    = hrel[WOFF_W +: IDX_W];
  assign woff    = hrel[WOFF_W-1:0];
  assign ent_ok  = offs[widx] != '1;

  assign i_valid = h_valid && in_area && ent_ok;
  assign h_err   = h_valid && in_area && !ent_ok;
  assign i_we    = h_we;
  assign i_wdata = h_wdata;
  assign i_addr  = {offs[widx], 2'b00} + IADDR_W'(woff);
  assign h_rdata = !in_area ? '0 : (ent_ok ? i_rdata : '1);
  assign i_fid   = ctl[widx][B_FUNC] ? fid[widx] : DFLT_FID;
  assign i_port  = (ctl[widx][B_PP] && ctl[widx][B_USE]) ? ctl[widx][PORT_W-1:0] : DFLT_PORT;
endmodule

// File: rtl/bar_window_xlat_chk.sv
module bar_window_xlat_chk #(
  parameter int NWIN = 4, parameter int WIN_BYTES = 4096,
  parameter int IADDR_W = 24, parameter int DATA_W = 32, parameter int HADDR_W = 16,
  parameter logic [HADDR_W-1:0] WIN_BASE = 16'h4000
) (
  input logic clk, input logic rst_n,
  input logic h_valid, input logic h_we, input logic [HADDR_W-1:0] h_addr,
  input logic [DATA_W-1:0] h_rdata, input logic h_err,
  input logic i_valid, input logic i_we, input logic [IADDR_W-1:0] i_addr
);
  localparam logic [HADDR_W-1:0] LIMIT = HADDR_W'(NWIN * WIN_BYTES);
  logic outside;
  assign outside = (h_addr < WIN_BASE) || (HADDR_W'(h_addr - WIN_BASE) >= LIMIT);

  // R5
  err_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n) h_err |-> !i_valid);
  // R5
  err_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_err && !h_we) |-> (h_rdata == '1));
  // R3
  dword_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    i_valid |-> (i_addr[1:0] == h_addr[1:0]));
  // R4
  fwd_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    i_valid |-> (h_valid && (i_we == h_we)));
  // R6
  outside_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outside |-> (!i_valid && !h_err && h_rdata == '0));
endmodule

bind bar_window_xlat bar_window_xlat_chk #(
  .NWIN(NWIN), .WIN_BYTES(WIN_BYTES), .IADDR_W(IADDR_W), .DATA_W(DATA_W),
  .HADDR_W(HADDR_W), .WIN_BASE(WIN_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .h_valid(h_valid), .h_we(h_we), .h_addr(h_addr),
  .h_rdata(h_rdata), .h_err(h_err), .i_valid(i_valid), .i_we(i_we), .i_addr(i_addr)
);

// File: tb/sim_bar_window_xlat.sv
module sim_bar_window_xlat;
  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0;
  logic [11:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic h_valid = 0, h_we = 0;
  logic [15:0] h_addr = 0;
  logic [31:0] h_wdata = 0, h_rdata, i_wdata, i_rdata;
  logic h_err, i_valid, i_we;
  logic [23:0] i_addr;
  logic [15:0] i_fid;
  logic [1:0] i_port;

  always #2.5 clk = ~clk;
  assign i_rdata = {8'hC3, i_addr};

  bar_window_xlat u0 (.*);

  int checks = 0, errors = 0;
  logic [21:0] m_off [4];
  logic [15:0] m_ctl [4], m_fid [4];

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(logic [11:0] a, logic [31:0] d);
    logic [15:0] c, f;
    @(negedge clk); cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 0;
    if (a >= 12'h100 && a < 12'h120 && a[1:0] == 0) begin
      if (a[2] == 0) m_off[a[4:3]] = d[21:0];
      else begin
        c = d[15:0]; f = d[31:16];
        if (c[4]) begin
          c[1:0] = 0; c[2] = 0; c[3] = 1;   // R7
          if (!f[15]) f = {12'd0, f[3:0]};  // R8
        end
        m_ctl[a[4:3]] = c; m_fid[a[4:3]] = f;
      end
    end
  endtask

  task automatic probe(int w, int o, bit we);
    logic [23:0] ea;
    @(negedge clk);
    h_valid = 1; h_we = we; h_addr = 16'(16'h4000 + w * 4096 + o);
    h_wdata = 32'hD00D_0000 + 32'(o); #1;
    ea = 24'({m_off[w], 2'b00} + o);
    if (m_off[w] == 22'h3FFFFF) begin
      chk("R5 err", 64'(h_err), 1); chk("R5 nofwd", 64'(i_valid), 0);
      if (!we) chk("R5 rdata", 64'(h_rdata), 64'hFFFFFFFF);
    end else begin
      chk("R3 addr", 64'(i_addr), 64'(ea));
      chk("R4 valid", 64'({i_valid, i_we, h_err}), 64'({1'b1, we, 1'b0}));
      if (we) chk("R4 wdata", 64'(i_wdata), 64'(h_wdata));
      else    chk("R4 rdata", 64'(h_rdata), 64'({8'hC3, ea}));
      chk("R9 fid", 64'(i_fid), 64'(m_ctl[w][4] ? m_fid[w] : 16'h0007));
      chk("R10 port", 64'(i_port), 64'((m_ctl[w][3] && m_ctl[w][2]) ? m_ctl[w][1:0] : 2'd1));
    end
  endtask

  task automatic cfg_read(logic [11:0] a, logic [31:0] exp, string req);
    @(negedge clk); cfg_addr = a; #1; chk(req, 64'(cfg_rdata), 64'(exp));
  endtask

  initial begin
    for (int n = 0; n < 4; n++) begin m_off[n] = '1; m_ctl[n] = 0; m_fid[n] = 0; end
    repeat (3) @(negedge clk); rst_n = 1;
    for (int n = 0; n < 4; n++) begin
      cfg_read(12'(12'h100 + 8*n), 32'h003FFFFF, "R1 base");
      cfg_read(12'(12'h104 + 8*n), 32'h0, "R1 pretend");
      probe(n, 8, 0);
    end
    // R2 base words, including wrap at the top of internal space
    cfg_write(12'h100, 32'hFFC0_0400);
    cfg_write(12'h108, 32'h0001_2340);
    cfg_write(12'h110, 32'h003F_FFFE);
    cfg_write(12'h118, 32'h0000_0000);
    cfg_read(12'h100, 32'h0000_0400, "R2 trunc");
    cfg_read(12'h110, 32'h003F_FFFE, "R2 readback");
    for (int n = 0; n < 4; n++) begin
      probe(n, 0, 0); probe(n, 4, 1); probe(n, 'h7FD, 0); probe(n, 'hFFC, 0); probe(n, 'hFFF, 1);
    end
    // R2 writes outside the admin range are ignored
    cfg_write(12'h0F8, 32'h0000_0055);
    cfg_write(12'h120, 32'h0000_0055);
    cfg_read(12'h120, 32'h0, "R2 outside read");
    cfg_read(12'h118, 32'h0, "R2 outside nochange");
    // R6 outside window area
    @(negedge clk); h_valid = 1; h_we = 0; h_addr = 16'h3FFC; #1;
    chk("R6 low", 64'({i_valid, h_err}), 0); chk("R6 rdata", 64'(h_rdata), 0);
    @(negedge clk); h_addr = 16'h8000; #1;
    chk("R6 high", 64'({i_valid, h_err}), 0);
    // R7, R8, R9, R10 pretend words
    cfg_write(12'h114, 32'h8ABC_0017);
    cfg_read(12'h114, 32'h8ABC_0018, "R7 normalise");
    probe(2, 16, 0);
    cfg_write(12'h114, 32'h0ABC_0010);
    cfg_read(12'h114, 32'h000C_0018, "R8 pf only");
    probe(2, 20, 0);
    cfg_write(12'h10C, 32'h1234_000E);
    cfg_read(12'h10C, 32'h1234_000E, "R10 stored");
    probe(1, 0, 1);
    chk("R10 port2", 64'(i_port), 2); chk("R9 default", 64'(i_fid), 7);
    cfg_write(12'h10C, 32'h1234_0006);
    probe(1, 0, 0);
    chk("R10 no override", 64'(i_port), 1);
    // R11 same-cycle relocation
    @(negedge clk); h_valid = 1; h_we = 0; h_addr = 16'h5010;
    cfg_wr = 1; cfg_addr = 12'h108; cfg_wdata = 32'h0000_0800; #1;
    chk("R11 old base", 64'(i_addr), 64'(24'h048D00 + 24'h10));
    @(negedge clk); cfg_wr = 0; m_off[1] = 22'h800; #1;
    chk("R11 new base", 64'(i_addr), 64'(24'h002010));
    // R5 invalidate a window again
    cfg_write(12'h118, 32'hFFFF_FFFF);
    probe(3, 12, 0); probe(3, 12, 1);
    @(negedge clk); h_valid = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule